// File: doc/BRIEF.md
# Register-file read-port stall arbiter

This block is the operand-read stage that follows register renaming. Each cycle it may receive a group of up to three renamed micro-ops. Each micro-op carries two source operands, and each source is tagged with where its value is found: the committed register file, a reorder entry that has completed but not retired, or a producer that has not executed yet. Only committed-file sources need the register file, and that file has just two read ports. Values from reorder entries and pending values cost no port.

The block gathers the distinct committed-file register numbers in the group. A number that occurs more than once is read only once. It then spreads these reads over as many cycles, called beats, as the two ports require. While a beat is not the last one, it holds the upstream queue by dropping its ready output. It drives up to two read requests per beat, taken in micro-op order.

A two-state machine tracks the beats. PH_LEAD is the first beat of a group and also the idle state. PH_TAIL covers every later beat, with a beat counter. The transitions are:
- LEAD_STAY: PH_LEAD stays in PH_LEAD when no group is presented or the group fits in one beat.
- LEAD_TO_TAIL: PH_LEAD goes to PH_TAIL with the counter at 1 when a presented group needs more than one beat.
- TAIL_STEP: PH_TAIL stays in PH_TAIL and increments the counter when the beat is not the last.
- TAIL_TO_LEAD: PH_TAIL returns to PH_LEAD on the last beat, or when valid drops.

Top module: `regread_port_arbiter`

## Requirements
- R1: After reset, with no group presented, trip_ready is 1 and no read request is enabled.
- R2: A source uses the committed file when its location code is 2'b00 and its micro-op valid bit is set. Such a source produces a read request for its register number within the group's beats.
- R3: Sources with code 2'b01 (unretired reorder entry), code 2'b10 (pending), or code 2'b11 (unused), and every source of a micro-op whose valid bit is clear, produce no read request.
- R4: Committed-file sources in one group that share a register number are merged. Each distinct number is requested exactly once.
- R5: The distinct numbers are issued in order of first appearance. The scan order is source 0 of micro-op 0, then source 1 of micro-op 0, then micro-op 1, and so on. Each beat fills port 0 before port 1, and earlier beats carry earlier numbers.
- R6: A group with N distinct committed reads occupies max(1, ceil(N/2)) beats. trip_ready is 0 in every beat except the last, which makes the group consumed on that beat's clock edge.
- R7: Every beat other than the last enables both read ports.
- R8: When trip_valid is 0, no read request is enabled. Port 1 is never enabled without port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trip_valid | input | 1 | A micro-op group is presented |
| trip_ready | output | 1 | The current beat is the group's last; the group is consumed at this edge |
| uop_valid | input | NUM_UOPS | Per-micro-op valid bits |
| src_loc | input | 4*NUM_UOPS | 2-bit location code per source; source s = 2*uop + operand at bits [2s+1:2s] |
| src_reg | input | 2*NUM_UOPS*REG_W | Register number per source, source s at bits [REG_W*s +: REG_W] |
| rd_en | output | NUM_PORTS | Read request enable per port |
| rd_reg | output | NUM_PORTS*REG_W | Register number per port, port p at bits [REG_W*p +: REG_W] |

## Verification
The assertions assume that the upstream side holds trip_valid and every source field stable while trip_ready is low. The request path is combinational from those inputs, so any change mid-group would make a new group. The bench obeys this rule: it changes inputs only after sampling a beat with trip_ready high, or during idle cycles with trip_valid low. Random register numbers are often drawn from a small range so that merges within a group occur often.

// File: rtl/rfrp_pkg.sv
package rfrp_pkg;

    typedef enum logic [1:0] {
        LOC_FILE = 2'b00,
        LOC_ROB  = 2'b01,
        LOC_WAIT = 2'b10,
        LOC_NONE = 2'b11
    } src_loc_e;

    typedef enum logic {
        PH_LEAD = 1'b0,
        PH_TAIL = 1'b1
    } phase_e;

    function automatic int ceil_div(int a, int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/rfrp_src_filter.sv
module rfrp_src_filter
    import rfrp_pkg::*;
#(
    parameter int NUM_UOPS = 3,
    localparam int NSRC = 2 * NUM_UOPS
) (
    input  logic [NUM_UOPS-1:0] uop_valid,
    input  logic [2*NSRC-1:0]   src_loc,
    output logic [NSRC-1:0]     need
);

    // a source needs a port only if it lives in the committed file
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign need[s] = uop_valid[s/2] &&
                         (src_loc_e'(src_loc[2*s +: 2]) == LOC_FILE);
    end

endmodule

// File: rtl/rfrp_dedup_rank.sv
module rfrp_dedup_rank
    import rfrp_pkg::*;
#(
    parameter int NUM_UOPS  = 3,
    parameter int NUM_PORTS = 2,
    parameter int REG_W     = 4,
    localparam int NSRC   = 2 * NUM_UOPS,
    localparam int CNT_W  = $clog2(NSRC + 1),
    localparam int MAXB   = ceil_div(NSRC, NUM_PORTS),
    localparam int BEAT_W = $clog2(MAXB + 1)
) (
    input  logic [NSRC-1:0]       need,
    input  logic [NSRC*REG_W-1:0] src_reg,
    output logic [NSRC-1:0]       first,
    output logic [NSRC*CNT_W-1:0] rank,
    output logic [BEAT_W-1:0]     total_beats
);

    logic [NSRC-1:0]  seen_before;
    logic [CNT_W-1:0] distinct;

    // an earlier committed source with the same number makes this one a repeat
    always_comb begin
        seen_before = '0;
        for (int s = 0; s < NSRC; s++) begin
            for (int t = 0; t < s; t++) begin
                if (need[t] && (src_reg[t*REG_W +: REG_W] == src_reg[s*REG_W +: REG_W])) begin
                    seen_before[s] = 1'b1;
                end
            end
        end
    end

    assign first = need & ~seen_before;

    // rank of each first occurrence = number of first occurrences ahead of it
    always_comb begin
        rank     = '0;
        distinct = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (first[s]) begin
                rank[s*CNT_W +: CNT_W] = distinct;
                distinct = distinct + 1'b1;
            end
        end
    end

    always_comb begin
        if (distinct == '0) begin
            total_beats = BEAT_W'(1);
        end else begin
            total_beats = BEAT_W'(ceil_div(int'(distinct), NUM_PORTS));
        end
    end

endmodule

// File: rtl/rfrp_beat_select.sv
module rfrp_beat_select
    import rfrp_pkg::*;
#(
    parameter int NUM_UOPS  = 3,
    parameter int NUM_PORTS = 2,
    parameter int REG_W     = 4,
    localparam int NSRC   = 2 * NUM_UOPS,
    localparam int CNT_W  = $clog2(NSRC + 1),
    localparam int MAXB   = ceil_div(NSRC, NUM_PORTS),
    localparam int BEAT_W = $clog2(MAXB + 1)
) (
    input  logic                       trip_valid,
    input  logic [BEAT_W-1:0]          beat_idx,
    input  logic [NSRC-1:0]            first,
    input  logic [NSRC*CNT_W-1:0]      rank,
    input  logic [NSRC*REG_W-1:0]      src_reg,
    output logic [NUM_PORTS-1:0]       rd_en,
    output logic [NUM_PORTS*REG_W-1:0] rd_reg
);

    // port p of beat b carries the distinct number of rank b*NUM_PORTS + p
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_comb begin
            rd_en[p]                 = 1'b0;
            rd_reg[p*REG_W +: REG_W] = '0;
            for (int s = 0; s < NSRC; s++) begin
                if (trip_valid && first[s] &&
                    (int'(rank[s*CNT_W +: CNT_W]) == int'(beat_idx) * NUM_PORTS + p)) begin
                    rd_en[p]                 = 1'b1;
                    rd_reg[p*REG_W +: REG_W] = src_reg[s*REG_W +: REG_W];
                end
            end
        end
    end

endmodule

// File: rtl/rfrp_phase_fsm.sv
module rfrp_phase_fsm
    import rfrp_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trip_valid,
    input  logic [BEAT_W-1:0] total_beats,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              trip_ready
);

    phase_e            state_q, state_d;
    logic [BEAT_W-1:0] cnt_q, cnt_d;
    logic              last_beat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_LEAD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        beat_idx   = (state_q == PH_TAIL) ? cnt_q : '0;
        last_beat  = (beat_idx == total_beats - 1'b1);
        trip_ready = !trip_valid || last_beat;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PH_LEAD: begin
                if (trip_valid && !last_beat) begin
                    state_d = PH_TAIL;
                    cnt_d   = BEAT_W'(1);
                end
            end
            PH_TAIL: begin
                if (!trip_valid || last_beat) begin
                    state_d = PH_LEAD;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/regread_port_arbiter.sv
module regread_port_arbiter
    import rfrp_pkg::*;
#(
    parameter int NUM_UOPS  = 3,
    parameter int NUM_PORTS = 2,
    parameter int REG_W     = 4,
    localparam int NSRC   = 2 * NUM_UOPS,
    localparam int CNT_W  = $clog2(NSRC + 1),
    localparam int MAXB   = ceil_div(NSRC, NUM_PORTS),
    localparam int BEAT_W = $clog2(MAXB + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       trip_valid,
    output logic                       trip_ready,
    input  logic [NUM_UOPS-1:0]        uop_valid,
    input  logic [2*NSRC-1:0]          src_loc,
    input  logic [NSRC*REG_W-1:0]      src_reg,
    output logic [NUM_PORTS-1:0]       rd_en,
    output logic [NUM_PORTS*REG_W-1:0] rd_reg
);

    logic [NSRC-1:0]       need;
    logic [NSRC-1:0]       first;
    logic [NSRC*CNT_W-1:0] rank;
    logic [BEAT_W-1:0]     total_beats;
    logic [BEAT_W-1:0]     beat_idx;

    rfrp_src_filter #(
        .NUM_UOPS (NUM_UOPS)
    ) i_filter (
        .uop_valid (uop_valid),
        .src_loc   (src_loc),
        .need      (need)
    );

    rfrp_dedup_rank #(
        .NUM_UOPS  (NUM_UOPS),
        .NUM_PORTS (NUM_PORTS),
        .REG_W     (REG_W)
    ) i_dedup (
        .need        (need),
        .src_reg     (src_reg),
        .first       (first),
        .rank        (rank),
        .total_beats (total_beats)
    );

    rfrp_phase_fsm #(
        .BEAT_W (BEAT_W)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .trip_valid  (trip_valid),
        .total_beats (total_beats),
        .beat_idx    (beat_idx),
        .trip_ready  (trip_ready)
    );

    rfrp_beat_select #(
        .NUM_UOPS  (NUM_UOPS),
        .NUM_PORTS (NUM_PORTS),
        .REG_W     (REG_W)
    ) i_select (
        .trip_valid (trip_valid),
        .beat_idx   (beat_idx),
        .first      (first),
        .rank       (rank),
        .src_reg    (src_reg),
        .rd_en      (rd_en),
        .rd_reg     (rd_reg)
    );

endmodule

// File: rtl/rfrp_checker.sv
module rfrp_checker
    import rfrp_pkg::*;
#(
    parameter int NUM_UOPS  = 3,
    parameter int NUM_PORTS = 2,
    parameter int REG_W     = 4,
    localparam int NSRC  = 2 * NUM_UOPS,
    localparam int MAXB  = ceil_div(NSRC, NUM_PORTS),
    localparam int RUN_W = $clog2(MAXB + 1) + 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       trip_valid,
    input logic                       trip_ready,
    input logic [NUM_UOPS-1:0]        uop_valid,
    input logic [2*NSRC-1:0]          src_loc,
    input logic [NSRC*REG_W-1:0]      src_reg,
    input logic [NUM_PORTS-1:0]       rd_en,
    input logic [NUM_PORTS*REG_W-1:0] rd_reg
);

    logic [RUN_W-1:0] stall_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_run <= '0;
        end else if (trip_valid && !trip_ready) begin
            stall_run <= stall_run + 1'b1;
        end else begin
            stall_run <= '0;
        end
    end

    // input rule: a stalled group is held unchanged (R6)
    a_r6_group_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(trip_valid && !trip_ready) |->
            (trip_valid && $stable(uop_valid) && $stable(src_loc) && $stable(src_reg)));

    a_r6_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_valid && !trip_ready) |-> (int'(stall_run) < MAXB - 1));

    a_r7_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_valid && !trip_ready) |-> (&rd_en));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_valid |-> (rd_en == '0));

    for (genvar p = 1; p < NUM_PORTS; p++) begin : g_packed
        a_r8_ports_packed: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en[p] |-> rd_en[p-1]);
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pa
        for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_pb
            a_r4_no_dup_beat: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en[p] && rd_en[q]) |->
                    (rd_reg[p*REG_W +: REG_W] != rd_reg[q*REG_W +: REG_W]));
        end
    end

endmodule

bind regread_port_arbiter rfrp_checker #(
    .NUM_UOPS  (NUM_UOPS),
    .NUM_PORTS (NUM_PORTS),
    .REG_W     (REG_W)
) i_rfrp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_valid (trip_valid),
    .trip_ready (trip_ready),
    .uop_valid  (uop_valid),
    .src_loc    (src_loc),
    .src_reg    (src_reg),
    .rd_en      (rd_en),
    .rd_reg     (rd_reg)
);

// File: tb/test_regread_port_arbiter.sv
`timescale 1ns/1ps
module test_regread_port_arbiter;

    localparam int NU = 3;
    localparam int NP = 2;
    localparam int RW = 4;
    localparam int NS = 2 * NU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             trip_valid;
    logic             trip_ready;
    logic [NU-1:0]    uop_valid;
    logic [2*NS-1:0]  src_loc;
    logic [NS*RW-1:0] src_reg;
    logic [NP-1:0]    rd_en;
    logic [NP*RW-1:0] rd_reg;

    int total = 0;
    int bad = 0;
    int exp_list[NS];
    int exp_n;

    regread_port_arbiter i_regread_port_arbiter (
        .clk(clk), .rst_n(rst_n), .trip_valid(trip_valid), .trip_ready(trip_ready),
        .uop_valid(uop_valid), .src_loc(src_loc), .src_reg(src_reg),
        .rd_en(rd_en), .rd_reg(rd_reg)
    );

    task automatic check(string tag, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic set_src(int u, int k, logic [1:0] loc, int r);
        int s = 2 * u + k;
        src_loc[2*s +: 2]   = loc;
        src_reg[RW*s +: RW] = RW'(r);
    endtask

    // distinct committed numbers in first-appearance order
    task automatic compute_expected();
        exp_n = 0;
        for (int s = 0; s < NS; s++) begin
            if (uop_valid[s/2] && src_loc[2*s +: 2] == 2'b00) begin
                int r = int'(src_reg[RW*s +: RW]);
                bit dup = 1'b0;
                for (int t = 0; t < exp_n; t++) if (exp_list[t] == r) dup = 1'b1;
                if (!dup) begin
                    exp_list[exp_n] = r;
                    exp_n++;
                end
            end
        end
    endtask

    task automatic run_triplet(string tag);
        int beats;
        compute_expected();
        beats = (exp_n == 0) ? 1 : (exp_n + NP - 1) / NP;
        trip_valid = 1'b1;
        for (int b = 0; b < beats; b++) begin
            #1;
            check({tag, " R6 ready"}, int'(trip_ready), (b == beats - 1) ? 1 : 0);
            for (int p = 0; p < NP; p++) begin
                int idx = b * NP + p;
                check({tag, " R2 port enable"}, int'(rd_en[p]), (idx < exp_n) ? 1 : 0);
                if (idx < exp_n) check({tag, " R5 port reg"}, int'(rd_reg[RW*p +: RW]), exp_list[idx]);
            end
            @(negedge clk);
        end
        trip_valid = 1'b0;
    endtask

    task automatic idle_cycle();
        trip_valid = 1'b0;
        uop_valid  = NU'($urandom);
        src_loc    = (2*NS)'($urandom);
        src_reg    = (NS*RW)'($urandom);
        #1;
        check("R8 idle enables", int'(rd_en), 0);
        check("R8 idle ready", int'(trip_ready), 1);
        @(negedge clk);
    endtask

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL R6 watchdog expired: got=1 exp=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        trip_valid = 1'b0;
        uop_valid  = '0;
        src_loc    = '0;
        src_reg    = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset ready", int'(trip_ready), 1);
        check("R1 reset enables", int'(rd_en), 0);
        @(negedge clk);
        idle_cycle();

        // R7: six distinct committed numbers -> three beats, full ports while stalled
        uop_valid = 3'b111;
        for (int s = 0; s < NS; s++) set_src(s/2, s%2, 2'b00, s + 1);
        run_triplet("R7 six distinct");

        // R4: all sources the same number -> one read, one beat
        for (int s = 0; s < NS; s++) set_src(s/2, s%2, 2'b00, 7);
        run_triplet("R4 all same");

        // R3: forwarded, pending, unused cost nothing
        set_src(0, 0, 2'b01, 1); set_src(0, 1, 2'b10, 2);
        set_src(1, 0, 2'b11, 3); set_src(1, 1, 2'b00, 9);
        set_src(2, 0, 2'b01, 4); set_src(2, 1, 2'b10, 5);
        run_triplet("R3 mixed locations");
        for (int s = 0; s < NS; s++) set_src(s/2, s%2, 2'b01, s);
        run_triplet("R3 none committed");

        // R3: invalid micro-ops contribute nothing
        uop_valid = 3'b001;
        for (int s = 0; s < NS; s++) set_src(s/2, s%2, 2'b00, s + 8);
        run_triplet("R3 invalid uops");

        // R5: merge across micro-ops, odd count leaves port 1 idle on last beat
        uop_valid = 3'b111;
        set_src(0, 0, 2'b00, 5); set_src(0, 1, 2'b00, 9);
        set_src(1, 0, 2'b00, 9); set_src(1, 1, 2'b00, 2);
        set_src(2, 0, 2'b01, 5); set_src(2, 1, 2'b00, 5);
        run_triplet("R5 cross merge");
        idle_cycle();

        for (int i = 0; i < 400; i++) begin
            uop_valid = NU'($urandom);
            for (int s = 0; s < NS; s++) begin
                int r = ($urandom % 2 == 0) ? int'($urandom % 4) : int'($urandom % 16);
                set_src(s/2, s%2, ($urandom % 3 == 0) ? 2'($urandom) : 2'b00, r);
            end
            run_triplet("R2 random");
            if ($urandom % 4 == 0) idle_cycle();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule